// File: doc/BRIEF.md
# Stepped Sawtooth Voice

This block produces one sawtooth voice for a sound generator. A 12-bit down-counting divider turns the system clock into step ticks. A step counter runs through fourteen positions. On every second tick a 6-bit rate value is added into an 8-bit accumulator. When the step counter wraps, the accumulator returns to zero. The top five accumulator bits are the voice output, so the ramp climbs in six increments and then drops back to zero.

The surrounding chip decodes the control registers and passes in the rate, the already-scaled period, a per-voice enable, a global halt and a clock-enable pulse. The output goes to an external mixer.

Top module: `sawVoice`

## Requirements
- R1: After reset the output is 0, the step position is 0 and the divider count is 0. The first active cycle therefore produces a step tick at once.
- R2: An active cycle is one where `tickEn` is 1 and `halt` is 0. On an active cycle where the divider count is 0, the divider reloads from `period` and the step counter advances. On any other active cycle the count is decremented. Ticks are therefore spaced `period`+1 active cycles apart.
- R3: When the step counter advances to an even position from 2 to 12, `rate` is added to the accumulator. When it advances to an odd position, the accumulator keeps its value.
- R4: When the step counter advances from position 13, it goes to 0 and the accumulator is cleared. It is not added to. One output period is 14×(`period`+1) active cycles.
- R5: `sawOut` equals accumulator bits 7 down to 3. The accumulator wraps modulo 256 with no saturation, so a rate of 63 gives 15 at position 12.
- R6: While `enable` is 0, the accumulator and the step position are forced to 0 at every clock edge, whatever `halt` and `tickEn` are. `sawOut` reads 0 from the next edge on.
- R7: The divider keeps counting while `enable` is 0 and is not reloaded by a disable. After re-enabling, the first step can therefore come early.
- R8: While `halt` is 1, the divider, step position and accumulator keep their values.
- R9: While `tickEn` is 0, the divider, step position and accumulator keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Clock enable; a cycle counts only while this is 1 |
| halt | input | 1 | Global freeze of all voice state |
| enable | input | 1 | Voice enable; 0 forces the ramp to zero |
| rate | input | 6 | Increment added on even steps |
| period | input | 12 | Divider reload value, already scaled |
| sawOut | output | 5 | Upper five accumulator bits |

## Verification
The bench walks through full 14-step cycles. A design that added on every tick, or on odd positions, would show the ramp one step early or at double slope. A design that cleared on the wrong position would show a seventh increment or a short ramp. A large rate is used to show the modulo-256 wrap at positions 10 and 12; a saturating design would stay at 31. A disable window placed partway through a divider interval separates a divider that keeps running from one that is reset, because the ramp then resumes one cycle too early or too late. The halt and clock-enable freezes are checked by resuming and confirming that no step was lost or gained.

// File: rtl/sawPkg.sv
package sawPkg;
  // Strobes passed from the step control to the accumulator datapath.
  typedef struct packed {
    logic addNow;     // step counter entered an even, non-zero position
    logic clearNow;   // step counter wrapped to position 0
    logic forceZero;  // voice disabled
  } sawStrobe_t;
endpackage

// File: rtl/sawControl.sv
module sawControl
  import sawPkg::*;
#(
  parameter int PERIOD_W   = 12,
  parameter int STEP_COUNT = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                halt,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  output sawStrobe_t          strobe
);
  localparam int STEP_W = $clog2(STEP_COUNT);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);

  logic [PERIOD_W-1:0] divCnt;
  logic [STEP_W-1:0]   stepPos;
  logic                active;
  logic                tick;
  logic                atLast;

  assign active = tickEn && !halt;
  assign tick   = active && (divCnt == '0);
  assign atLast = (stepPos == LAST_STEP);

  // Divider runs regardless of enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      divCnt <= '0;
    else if (active)
      divCnt <= (divCnt == '0) ? period : divCnt - PERIOD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stepPos <= '0;
    else if (!enable)
      stepPos <= '0;
    else if (tick)
      stepPos <= atLast ? '0 : stepPos + STEP_W'(1);
  end

  // An odd current position means the next position is even.
  always_comb begin
    strobe.forceZero = !enable;
    strobe.clearNow  = enable && tick && atLast;
    strobe.addNow    = enable && tick && stepPos[0] && !atLast;
  end
endmodule

// File: rtl/sawDatapath.sv
module sawDatapath
  import sawPkg::*;
#(
  parameter int RATE_W = 6,
  parameter int ACC_W  = 8,
  parameter int OUT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  sawStrobe_t        strobe,
  input  logic [RATE_W-1:0] rate,
  output logic [OUT_W-1:0]  sawOut
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      acc <= '0;
    else if (strobe.forceZero || strobe.clearNow)
      acc <= '0;
    else if (strobe.addNow)
      acc <= acc + ACC_W'(rate);
  end

  assign sawOut = acc[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/sawVoice.sv
module sawVoice
  import sawPkg::*;
#(
  parameter int PERIOD_W   = 12,
  parameter int RATE_W     = 6,
  parameter int ACC_W      = 8,
  parameter int OUT_W      = 5,
  parameter int STEP_COUNT = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                halt,
  input  logic                enable,
  input  logic [RATE_W-1:0]   rate,
  input  logic [PERIOD_W-1:0] period,
  output logic [OUT_W-1:0]    sawOut
);
  sawStrobe_t strobe;

  sawControl #(.PERIOD_W(PERIOD_W), .STEP_COUNT(STEP_COUNT)) u_control (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .halt(halt),
    .enable(enable), .period(period), .strobe(strobe)
  );

  sawDatapath #(.RATE_W(RATE_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rate(rate), .sawOut(sawOut)
  );
endmodule

// File: rtl/sawVoiceChecker.sv
module sawVoiceChecker #(
  parameter int PERIOD_W = 12,
  parameter int RATE_W   = 6,
  parameter int OUT_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                halt,
  input logic                enable,
  input logic [RATE_W-1:0]   rate,
  input logic [PERIOD_W-1:0] period,
  input logic [OUT_W-1:0]    sawOut
);
  // R1: output is zero after a reset edge
  a_r1_reset_zero: assert property (@(posedge clk) !rstN |=> sawOut == '0);

  // R6: disabled voice reads zero after the next edge
  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> sawOut == '0);

  // R8: halt freezes the ramp
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (halt && enable) |=> sawOut == $past(sawOut));

  // R9: clock enable low freezes the ramp
  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && enable) |=> $stable(sawOut));
endmodule

bind sawVoice sawVoiceChecker #(.PERIOD_W(PERIOD_W), .RATE_W(RATE_W), .OUT_W(OUT_W)) u_checker (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .halt(halt), .enable(enable),
  .rate(rate), .period(period), .sawOut(sawOut)
);

// File: tb/test_sawVoice.sv
module test_sawVoice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        halt = 1'b0;
  logic        enable = 1'b0;
  logic [5:0]  rate = '0;
  logic [11:0] period = '0;
  logic [4:0]  sawOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sawVoice i_sawVoice (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .halt(halt), .enable(enable),
    .rate(rate), .period(period), .sawOut(sawOut)
  );

  function automatic int expOut(int r, int s);
    return ((r * (s / 2)) & 255) >> 3;
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: sawOut=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clkStep(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; enable = 1'b0; halt = 1'b0; tickEn = 1'b1;
    period = '0; rate = '0;
    clkStep(2);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check("R1", sawOut, 0);
  endtask

  task automatic testRamp();   // R3 R4 R5
    doReset();
    rate = 6'd8; enable = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      clkStep(1);
      check((k % 14 == 0) ? "R4" : "R3", sawOut, expOut(8, k % 14));
    end
  endtask

  task automatic testWrap();   // R5
    doReset();
    rate = 6'd63; enable = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      clkStep(1);
      check("R5", sawOut, expOut(63, k % 14));
    end
  endtask

  task automatic testPeriod(); // R2 R4
    doReset();
    rate = 6'd8; period = 12'd2; enable = 1'b1;
    clkStep(3);
    check("R2", sawOut, 0);
    clkStep(1);
    check("R2", sawOut, 1);
    clkStep(35);
    check("R4", sawOut, 6);
    clkStep(1);
    check("R4", sawOut, 0);
  endtask

  task automatic testDisable(); // R6 R7
    doReset();
    rate = 6'd8; period = 12'd3; enable = 1'b1;
    clkStep(5);
    check("R3", sawOut, 1);
    enable = 1'b0;
    clkStep(1);
    check("R6", sawOut, 0);
    clkStep(1);
    check("R6", sawOut, 0);
    enable = 1'b1;
    clkStep(5);
    check("R7", sawOut, 0);
    clkStep(1);
    check("R7", sawOut, 1);
  endtask

  task automatic testHalt();   // R8
    doReset();
    rate = 6'd8; enable = 1'b1;
    clkStep(4);
    check("R8", sawOut, 2);
    halt = 1'b1;
    clkStep(5);
    check("R8", sawOut, 2);
    halt = 1'b0;
    clkStep(1);
    check("R8", sawOut, 2);
    clkStep(1);
    check("R8", sawOut, 3);
  endtask

  task automatic testGate();   // R9
    doReset();
    rate = 6'd16; enable = 1'b1;
    clkStep(3);
    check("R9", sawOut, 2);
    tickEn = 1'b0;
    clkStep(6);
    check("R9", sawOut, 2);
    tickEn = 1'b1;
    clkStep(1);
    check("R9", sawOut, 4);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: sawOut=%0d expected=finish", sawOut);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testRamp();
    testWrap();
    testPeriod();
    testDisable();
    testHalt();
    testGate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule